// File: doc/BRIEF.md
# Fault-Aware Mesh Route Selector

This block is the route computation stage of a six-port router in a two-dimensional mesh. In this mesh every core has two attachments: a master link to its own switch, and a slave link to the switch one column to its west. The switch in the last column serves the column-0 core of its own row through the slave link. Each request carries the current switch position, the destination core position, the port the packet entered on, the direction it was travelling, and one fault flag for each of the four mesh neighbours. The block answers with a one-hot output-port choice. It registers that choice behind a valid/ready handshake.

Routing is dimension order: the X offset is resolved first, then the Y offset. When the preferred neighbour is flagged faulty, is off the mesh, or would send the packet back the way it came, a fixed set of detour rules picks a replacement. An X-direction detour turns toward the destination row, follows a special rule next to the west edge, and otherwise goes south, or north on the south edge. A Y-direction detour steps sideways. If the replacement is also unusable, the block reports a route error instead of a grant.

Top module: `fault_xy_route`

## Requirements
- R1: When the current coordinates equal the destination coordinates, the block selects the local master port, out_port bit 4 (6'b010000).
- R2: When the current switch is the slave switch of the destination core, the block selects the local slave port, out_port bit 5 (6'b100000). This applies when the destination is in the same row and either its column is current+1, or the current switch is in the last column and the destination column is 0.
- R3: Otherwise the preferred hop is East (bit 2) if dst_x>cur_x, West (bit 3) if dst_x<cur_x, else North (bit 0) if dst_y>cur_y, else South (bit 1). North is increasing y, and y=0 is the south edge. If that hop is usable it is granted, and fault flags on the other neighbours have no effect. nbr_fault bit 0 is N, bit 1 is S, bit 2 is E and bit 3 is W.
- R4: When a preferred East or West hop is blocked, the block picks North if dst_y>cur_y and South if dst_y<cur_y.
- R5: When a West hop is blocked in the destination row, the destination is in column 0 and the current switch is in column 1, the block picks East.
- R6: Any other blocked X hop in the destination row goes South, or North when cur_y is 0.
- R7: When a preferred North or South hop is blocked, the block picks East, or West when the current switch is in the last column.
- R8: If in_port is a mesh port (codes 0 to 3) and the preferred hop is the reverse of prev_dir, the hop counts as blocked. Reverse means N and S swap, and E and W swap; direction codes are N=0, S=1, E=2, W=3. For a local in_port (4 = master, 5 = slave) no such check is made.
- R9: A mesh port that is flagged faulty or lies off the mesh is never granted. If the detour choice is unusable, the block sets route_error=1 with out_port=0.
- R10: A request is taken when req_valid and req_ready are both high. Its result appears with out_valid on the next cycle. req_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, the result is held unchanged.
- R11: After reset out_valid is 0, and reset clears it at once. Whenever out_valid is 1 and route_error is 0, out_port has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| cur_x | input | XW | Current switch column |
| cur_y | input | YW | Current switch row |
| dst_x | input | XW | Destination core column |
| dst_y | input | YW | Destination core row |
| in_port | input | 3 | Entry port code (0-3 mesh, 4 master, 5 slave) |
| prev_dir | input | 2 | Direction travelled on the previous hop |
| nbr_fault | input | 4 | Neighbour fault flags {W,E,S,N} |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Consumer takes the result |
| out_port | output | 6 | One-hot port choice {LS,LM,W,E,S,N} |
| route_error | output | 1 | No usable port found |

## Verification
The bench targets the rule boundaries. The column-1 eastward escape would become a southward turn if the column test were off by one. The south-edge flip would steer a packet off the mesh, where the error path must catch it. The wrap-around slave delivery from the last column would be routed west if the wrap were missed. Reversal detection is driven once from a mesh port and once from a local port; a design ignoring in_port would detour the local case. Back-pressure holds one result while a second request waits, and a design that loaded during the stall would show the second answer early.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [2:0] {
    DIR_N  = 3'd0,
    DIR_S  = 3'd1,
    DIR_E  = 3'd2,
    DIR_W  = 3'd3,
    DIR_LM = 3'd4,
    DIR_LS = 3'd5
  } port_e;

  localparam int NUM_PORTS = 6;
  localparam int NUM_MESH  = 4;
endpackage

// File: rtl/frc_xy_pref.sv
module frc_xy_pref
  import frc_pkg::*;
#(
  parameter int COLS = 4,
  parameter int XW   = 2,
  parameter int YW   = 2
) (
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output port_e         pref
);
  localparam logic [XW-1:0] LAST_COL = XW'(COLS - 1);

  logic same_row;
  logic slave_hit;

  always_comb begin
    same_row  = (cur_y == dst_y);
    slave_hit = same_row &&
                (((cur_x != LAST_COL) && (dst_x == cur_x + 1'b1)) ||
                 ((cur_x == LAST_COL) && (dst_x == '0)));
    if (same_row && (cur_x == dst_x))      pref = DIR_LM;
    else if (slave_hit)                    pref = DIR_LS;
    else if (dst_x > cur_x)                pref = DIR_E;
    else if (dst_x < cur_x)                pref = DIR_W;
    else if (dst_y > cur_y)                pref = DIR_N;
    else                                   pref = DIR_S;
  end
endmodule

// File: rtl/frc_detour.sv
module frc_detour
  import frc_pkg::*;
#(
  parameter int COLS = 4,
  parameter int ROWS = 4,
  parameter int XW   = 2,
  parameter int YW   = 2
) (
  input  logic [XW-1:0]       cur_x,
  input  logic [YW-1:0]       cur_y,
  input  logic [XW-1:0]       dst_x,
  input  logic [YW-1:0]       dst_y,
  input  port_e               pref,
  input  logic [2:0]          in_port,
  input  logic [1:0]          prev_dir,
  input  logic [NUM_MESH-1:0] nbr_fault,
  output port_e               sel,
  output logic                err
);
  localparam logic [XW-1:0] LAST_COL = XW'(COLS - 1);
  localparam logic [YW-1:0] LAST_ROW = YW'(ROWS - 1);

  logic [NUM_MESH-1:0] exists;
  logic [NUM_MESH-1:0] usable;
  logic [2:0]          p;
  logic                mesh_in;
  logic                reversal;
  logic                blocked;
  logic [1:0]          cand;

  always_comb begin
    exists[0] = (cur_y != LAST_ROW);
    exists[1] = (cur_y != '0);
    exists[2] = (cur_x != LAST_COL);
    exists[3] = (cur_x != '0);
    usable    = exists & ~nbr_fault;
  end

  always_comb begin
    p        = pref;
    mesh_in  = (in_port < 3'd4);
    reversal = mesh_in && !p[2] && (p[1:0] == {prev_dir[1], ~prev_dir[0]});
    blocked  = !usable[p[1:0]] || reversal;

    if (p[1]) begin
      if (dst_y > cur_y)                                  cand = 2'd0;
      else if (dst_y < cur_y)                             cand = 2'd1;
      else if (p[0] && (dst_x == '0) && (cur_x == XW'(1))) cand = 2'd2;
      else if (cur_y == '0)                               cand = 2'd0;
      else                                                cand = 2'd1;
    end else begin
      cand = (cur_x != LAST_COL) ? 2'd2 : 2'd3;
    end

    sel = pref;
    err = 1'b0;
    if (!p[2] && blocked) begin
      if (usable[cand]) sel = port_e'({1'b0, cand});
      else              err = 1'b1;
    end
  end
endmodule

// File: rtl/frc_out_reg.sv
module frc_out_reg
  import frc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  port_e                sel,
  input  logic                 err,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NUM_PORTS-1:0] out_port,
  output logic                 route_error
);
  logic                 load;
  logic                 valid_d;
  logic [NUM_PORTS-1:0] port_d;
  logic                 err_d;

  always_comb begin
    req_ready = !out_valid || out_ready;
    load      = req_valid && req_ready;
    valid_d   = out_valid && !out_ready;
    port_d    = out_port;
    err_d     = route_error;
    if (load) begin
      valid_d = 1'b1;
      port_d  = err ? '0 : (NUM_PORTS'(1) << sel);
      err_d   = err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_port    <= '0;
      route_error <= 1'b0;
    end else begin
      out_valid <= valid_d;
      if (load) begin
        out_port    <= port_d;
        route_error <= err_d;
      end
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(route_error)));

  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);
endmodule

// File: rtl/fault_xy_route.sv
module fault_xy_route
  import frc_pkg::*;
#(
  parameter int COLS = 4,
  parameter int ROWS = 4,
  parameter int XW   = (COLS > 1) ? $clog2(COLS) : 1,
  parameter int YW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [2:0]    in_port,
  input  logic [1:0]    prev_dir,
  input  logic [3:0]    nbr_fault,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [5:0]    out_port,
  output logic          route_error
);
  port_e pref;
  port_e sel;
  logic  err;
  logic  take;

  assign take = req_valid && req_ready;

  frc_xy_pref #(.COLS(COLS), .XW(XW), .YW(YW)) pref_i (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y), .pref(pref)
  );

  frc_detour #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW)) detour_i (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .pref(pref), .in_port(in_port), .prev_dir(prev_dir),
    .nbr_fault(nbr_fault), .sel(sel), .err(err)
  );

  frc_out_reg out_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .sel(sel), .err(err), .out_valid(out_valid), .out_ready(out_ready),
    .out_port(out_port), .route_error(route_error)
  );

  // R11
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !route_error) |-> $onehot(out_port));

  // R9
  error_no_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && route_error) |-> (out_port == 6'd0));

  // R9
  no_faulty_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(take)) |-> ((out_port[3:0] & $past(nbr_fault)) == 4'd0));

  // R9
  no_west_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(take) && ($past(cur_x) == '0)) |-> !out_port[3]);

  // R1
  arrive_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(take) && ($past(cur_x) == $past(dst_x)) &&
     ($past(cur_y) == $past(dst_y))) |-> (out_port == 6'b010000));
endmodule

// File: tb/fault_xy_route_tb_top.sv
`timescale 1ns/1ps
module fault_xy_route_tb_top;
  typedef struct packed {
    logic [1:0] cx;
    logic [1:0] cy;
    logic [1:0] dx;
    logic [1:0] dy;
    logic [2:0] inp;
    logic [1:0] prv;
    logic [3:0] flt;
    logic [5:0] ep;
    logic       ee;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd1,2'd1,2'd1,2'd1,3'd4,2'd0,4'b0000,6'b010000,1'b0}, // R1
    '{2'd1,2'd1,2'd2,2'd1,3'd4,2'd0,4'b0000,6'b100000,1'b0}, // R2
    '{2'd3,2'd2,2'd0,2'd2,3'd4,2'd0,4'b0000,6'b100000,1'b0}, // R2 wrap
    '{2'd0,2'd0,2'd3,2'd0,3'd4,2'd0,4'b1011,6'b000100,1'b0}, // R3 other faults ignored
    '{2'd2,2'd1,2'd0,2'd1,3'd4,2'd0,4'b0000,6'b001000,1'b0}, // R3
    '{2'd1,2'd1,2'd1,2'd3,3'd4,2'd0,4'b0000,6'b000001,1'b0}, // R3
    '{2'd1,2'd3,2'd1,2'd0,3'd4,2'd0,4'b0000,6'b000010,1'b0}, // R3
    '{2'd0,2'd1,2'd3,2'd3,3'd4,2'd0,4'b0100,6'b000001,1'b0}, // R4
    '{2'd0,2'd2,2'd3,2'd0,3'd4,2'd0,4'b0100,6'b000010,1'b0}, // R4
    '{2'd1,2'd2,2'd0,2'd2,3'd4,2'd0,4'b1000,6'b000100,1'b0}, // R5
    '{2'd3,2'd2,2'd1,2'd2,3'd4,2'd0,4'b1000,6'b000010,1'b0}, // R6
    '{2'd3,2'd0,2'd1,2'd0,3'd4,2'd0,4'b1000,6'b000001,1'b0}, // R6 south edge
    '{2'd2,2'd1,2'd0,2'd1,3'd3,2'd2,4'b0000,6'b000010,1'b0}, // R8 mesh reversal
    '{2'd2,2'd1,2'd0,2'd1,3'd4,2'd2,4'b0000,6'b001000,1'b0}, // R8 local entry
    '{2'd1,2'd1,2'd1,2'd3,3'd4,2'd0,4'b0001,6'b000100,1'b0}, // R7
    '{2'd3,2'd1,2'd3,2'd3,3'd4,2'd0,4'b0001,6'b001000,1'b0}, // R7 east edge
    '{2'd3,2'd0,2'd1,2'd0,3'd4,2'd0,4'b1001,6'b000000,1'b1}, // R9
    '{2'd3,2'd1,2'd3,2'd3,3'd4,2'd0,4'b1001,6'b000000,1'b1}  // R9
  };
  localparam string TAGS [NV] = '{"R1","R2","R2","R3","R3","R3","R3","R4","R4",
                                  "R5","R6","R6","R8","R8","R7","R7","R9","R9"};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, out_valid, out_ready, route_error;
  logic [1:0] cur_x, cur_y, dst_x, dst_y, prev_dir;
  logic [2:0] in_port;
  logic [3:0] nbr_fault;
  logic [5:0] out_port;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fault_xy_route dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .in_port(in_port), .prev_dir(prev_dir), .nbr_fault(nbr_fault),
    .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
    .route_error(route_error)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cur_x = v.cx; cur_y = v.cy; dst_x = v.dx; dst_y = v.dy;
    in_port = v.inp; prev_dir = v.prv; nbr_fault = v.flt;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b1;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    check("R11 reset valid/ready", {6'd0, out_valid, req_ready}, 8'b01);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      req_valid = 1'b1;
      @(negedge clk);
      check(TAGS[i], {out_valid, route_error, out_port}, {1'b1, VECS[i].ee, VECS[i].ep});
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 idle drop", {7'd0, out_valid}, 8'd0);

    // R10 back-pressure: hold first result, second waits
    out_ready = 1'b0;
    drive(VECS[0]); req_valid = 1'b1;
    @(negedge clk);
    check("R10 first result", {out_valid, route_error, out_port}, {2'b10, 6'b010000});
    check("R10 ready low", {7'd0, req_ready}, 8'd0);
    drive(VECS[5]);
    repeat (2) @(negedge clk);
    check("R10 held", {out_valid, route_error, out_port}, {2'b10, 6'b010000});
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 second result", {out_valid, route_error, out_port}, {2'b10, 6'b000001});
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 drained", {7'd0, out_valid}, 8'd0);

    // R11 asynchronous clear while a result is held
    out_ready = 1'b0; drive(VECS[1]); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    check("R11 async clear", {7'd0, out_valid}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule